// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Unit

This unit makes a coarse reciprocal estimate of a floating-point operand. It changes only the exponent. The sign is kept, the biased exponent field is replaced by its bitwise complement, and the fraction is cleared. An operand whose exponent field is zero gets a fixed exponent instead: all ones with the lowest bit cleared. A NaN operand is quietened and passed through. When default-NaN mode is on, every NaN is replaced by the canonical default NaN. A signaling NaN raises the invalid flag. When flush-to-zero is on, a subnormal operand is treated as a signed zero, and a flag reports that it was flushed.

A two-bit format select chooses half, single or double precision. The unit takes one operand on each cycle that the input valid is high. The result, the flags and the output valid come from a register stage and appear on the next clock edge. They hold their values while no new operand is presented. A narrow result sits in the low bits of the 64-bit result bus, and the bits above it are zero.

Top module: `recip_exp_unit`

## Requirements
- R1: `out_vld` is high exactly in the cycle after a cycle with `in_vld` high. While `in_vld` is low, `result`, `invalid` and `dnorm_flag` keep their previous values.
- R2: `fmt` encodes the format as follows: 0 is half (sign at bit 15, exponent 14:10, fraction 9:0), 1 is single (sign 31, exponent 30:23, fraction 22:0), 2 is double (sign 63, exponent 62:52, fraction 51:0), and 3 behaves as double. Operand bits above the chosen format are ignored, and result bits above it are zero.
- R3: For a non-NaN operand with a nonzero exponent, the result exponent is the bitwise complement of the operand exponent. The sign is kept and the fraction is zero.
- R4: For a non-NaN operand with a zero exponent field, the result exponent is 0x1E (half), 0xFE (single) or 0x7FE (double). The sign is kept and the fraction is zero.
- R5: An infinity operand gives a zero of the same sign.
- R6: With default-NaN mode off, a quiet NaN (top fraction bit set) is returned unchanged, and `invalid` stays low.
- R7: A signaling NaN (nonzero fraction with the top fraction bit clear) sets `invalid`. With default-NaN mode off, the result is that NaN with its top fraction bit set. A non-NaN operand never sets `invalid`.
- R8: With default-NaN mode on, any NaN gives the positive default NaN: 0x7E00, 0x7FC00000 or 0x7FF8000000000000. `invalid` is set only for a signaling NaN.
- R9: With flush-to-zero on, a subnormal operand sets `dnorm_flag` and gives the same result as a zero of its sign. With flush-to-zero off, or for a normal operand, `dnorm_flag` is low.
- R10: While reset is asserted, `out_vld`, `result`, `invalid` and `dnorm_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand present this cycle |
| fmt | input | 2 | Format select (0 half, 1 single, 2 or 3 double) |
| opnd | input | 64 | Operand, right-aligned for narrow formats |
| dn_mode | input | 1 | Default-NaN mode enable |
| ftz_mode | input | 1 | Flush-to-zero enable for subnormal operands |
| out_vld | output | 1 | Result registered from the previous cycle's operand |
| result | output | 64 | Reciprocal-exponent result, zero-extended |
| invalid | output | 1 | Invalid operation (signaling NaN operand) |
| dnorm_flag | output | 1 | Subnormal operand was flushed |

## Verification
The properties assume that `fmt`, `opnd` and both mode bits are settled at the clock edge where `in_vld` is sampled high. The properties compare each registered output with the inputs sampled one edge earlier, so they also assume that reset has been released for at least one cycle. The bench drives all inputs on the falling edge and samples outputs on the following falling edge, which keeps every operand stable around its capturing edge. The vector table puts junk in the operand bits above each narrow format, and it includes format code 3, to show that only the chosen field affects the result.

// File: rtl/rexp_pkg.sv
package rexp_pkg;
  localparam int DATA_W  = 64;
  localparam int NUM_FMT = 3;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_WIDE   = 2'd3
  } fmt_e;

  localparam int EXP_W  [NUM_FMT] = '{5, 8, 11};
  localparam int FRAC_W [NUM_FMT] = '{10, 23, 52};

  function automatic logic [1:0] fmt_index(input logic [1:0] f);
    return (f == FMT_WIDE) ? 2'(FMT_DOUBLE) : f;
  endfunction
endpackage

// File: rtl/rexp_lane.sv
module rexp_lane #(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W = EW + FW + 1
) (
  input  logic [W-1:0] opnd,
  input  logic         dn_mode,
  input  logic         ftz_mode,
  output logic [W-1:0] res,
  output logic         inv,
  output logic         flushed
);
  logic          sgn;
  logic [EW-1:0] ex;
  logic [FW-1:0] fr;
  logic          ex_ones, ex_zero, fr_nz, is_nan, is_snan;

  assign sgn     = opnd[W-1];
  assign ex      = opnd[W-2:FW];
  assign fr      = opnd[FW-1:0];
  assign ex_ones = &ex;
  assign ex_zero = ~|ex;
  assign fr_nz   = |fr;
  assign is_nan  = ex_ones & fr_nz;
  assign is_snan = is_nan & ~fr[FW-1];

  always_comb begin
    inv     = is_snan;
    flushed = ftz_mode & ex_zero & fr_nz;
    if (is_nan) begin
      if (dn_mode) begin
        res = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
      end else begin
        res         = opnd;
        res[FW-1]   = 1'b1;
      end
    end else if (ex_zero) begin
      res = {sgn, {(EW-1){1'b1}}, 1'b0, {FW{1'b0}}};
    end else begin
      res = {sgn, ~ex, {FW{1'b0}}};
    end
  end
endmodule

// File: rtl/rexp_pick.sv
module rexp_pick
  import rexp_pkg::*;
#(
  parameter int N = NUM_FMT,
  parameter int DW = DATA_W
) (
  input  logic [1:0]         fmt,
  input  logic [N-1:0][DW-1:0] cand,
  input  logic [N-1:0]       inv_c,
  input  logic [N-1:0]       flush_c,
  output logic [DW-1:0]      res,
  output logic               inv,
  output logic               flushed
);
  logic [1:0] idx;
  assign idx = fmt_index(fmt);

  always_comb begin
    res     = '0;
    inv     = 1'b0;
    flushed = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (idx == 2'(k)) begin
        res     = cand[k];
        inv     = inv_c[k];
        flushed = flush_c[k];
      end
    end
  end
endmodule

// File: rtl/recip_exp_unit.sv
module recip_exp_unit
  import rexp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [1:0]        fmt,
  input  logic [DATA_W-1:0] opnd,
  input  logic              dn_mode,
  input  logic              ftz_mode,
  output logic              out_vld,
  output logic [DATA_W-1:0] result,
  output logic              invalid,
  output logic              dnorm_flag
);
  logic [NUM_FMT-1:0][DATA_W-1:0] cand;
  logic [NUM_FMT-1:0]             inv_c, flush_c;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int LW = EXP_W[g] + FRAC_W[g] + 1;
    logic [LW-1:0] lane_res;

    rexp_lane #(.EW(EXP_W[g]), .FW(FRAC_W[g])) u_lane (
      .opnd     (opnd[LW-1:0]),
      .dn_mode  (dn_mode),
      .ftz_mode (ftz_mode),
      .res      (lane_res),
      .inv      (inv_c[g]),
      .flushed  (flush_c[g])
    );

    always_comb begin
      cand[g]         = '0;
      cand[g][LW-1:0] = lane_res;
    end
  end

  logic [DATA_W-1:0] sel_res;
  logic              sel_inv, sel_flush;

  rexp_pick u_pick (
    .fmt     (fmt),
    .cand    (cand),
    .inv_c   (inv_c),
    .flush_c (flush_c),
    .res     (sel_res),
    .inv     (sel_inv),
    .flushed (sel_flush)
  );

  logic              vld_d;
  logic [DATA_W-1:0] res_d;
  logic              inv_d, flush_d;

  always_comb begin
    vld_d   = in_vld;
    res_d   = result;
    inv_d   = invalid;
    flush_d = dnorm_flag;
    if (in_vld) begin
      res_d   = sel_res;
      inv_d   = sel_inv;
      flush_d = sel_flush;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      result     <= '0;
      invalid    <= 1'b0;
      dnorm_flag <= 1'b0;
    end else begin
      out_vld    <= vld_d;
      result     <= res_d;
      invalid    <= inv_d;
      dnorm_flag <= flush_d;
    end
  end
endmodule

// File: rtl/rexp_chk.sv
module rexp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [1:0]  fmt,
  input logic [63:0] opnd,
  input logic        dn_mode,
  input logic        ftz_mode,
  input logic        out_vld,
  input logic [63:0] result,
  input logic        invalid,
  input logic        dnorm_flag
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(result) && $stable(invalid))); // R1
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fmt == 2'd0) |=> (result[63:16] == 48'h0)); // R2
  AST_SGL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fmt == 2'd1 && opnd[30:23] != 8'hFF) |=>
      (result[22:0] == 23'h0 && result[63:32] == 32'h0 && result[31] == $past(opnd[31]))); // R3
  AST_HALF_ZERO_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fmt == 2'd0 && opnd[14:10] == 5'h0) |=>
      (result[15:0] == {$past(opnd[15]), 15'h7800})); // R4
  AST_SGL_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fmt == 2'd1 && opnd[30:23] != 8'hFF) |=> !invalid); // R7
  AST_DBL_DEFAULT_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fmt == 2'd2 && dn_mode && opnd[62:52] == 11'h7FF && opnd[51:0] != 52'h0) |=>
      (result == 64'h7FF8000000000000)); // R8
  AST_FLUSH_NEEDS_FTZ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !ftz_mode) |=> !dnorm_flag); // R9
endmodule

bind recip_exp_unit rexp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_vld     (in_vld),
  .fmt        (fmt),
  .opnd       (opnd),
  .dn_mode    (dn_mode),
  .ftz_mode   (ftz_mode),
  .out_vld    (out_vld),
  .result     (result),
  .invalid    (invalid),
  .dnorm_flag (dnorm_flag)
);

// File: tb/tb_recip_exp_unit.sv
module tb_recip_exp_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [1:0]  fmt;
  logic [63:0] opnd;
  logic        dn_mode, ftz_mode;
  logic        out_vld;
  logic [63:0] result;
  logic        invalid, dnorm_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  recip_exp_unit dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .fmt(fmt), .opnd(opnd),
    .dn_mode(dn_mode), .ftz_mode(ftz_mode), .out_vld(out_vld),
    .result(result), .invalid(invalid), .dnorm_flag(dnorm_flag)
  );

  // entry: {fmt[1:0], dn, ftz, operand[63:0], expected[63:0], inv, flushed}
  localparam int NV = 23;
  localparam logic [133:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_3C00, 64'h0000_0000_0000_4000, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_BC00, 64'h0000_0000_0000_C000, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_7800, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_7C00, 64'h0000_0000_0000_0000, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_7D00, 64'h0000_0000_0000_7F00, 1'b1, 1'b0},
    {2'd0, 1'b1, 1'b0, 64'h0000_0000_0000_FE01, 64'h0000_0000_0000_7E00, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b0, 64'h0000_0000_C120_0000, 64'h0000_0000_BE80_0000, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b1, 64'h0000_0000_8000_0001, 64'h0000_0000_FF00_0000, 1'b0, 1'b1},
    {2'd1, 1'b0, 1'b0, 64'h0000_0000_8000_0001, 64'h0000_0000_FF00_0000, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b0, 64'h0000_0000_7FC0_1234, 64'h0000_0000_7FC0_1234, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b0, 64'h0000_0000_FF80_0001, 64'h0000_0000_FFC0_0001, 1'b1, 1'b0},
    {2'd1, 1'b1, 1'b0, 64'h0000_0000_7F80_0001, 64'h0000_0000_7FC0_0000, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b0, 64'h0000_0000_FF80_0000, 64'h0000_0000_8000_0000, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b0, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b0, 64'h0000_0000_0000_0000, 64'h7FE0_0000_0000_0000, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b1, 64'h800F_FFFF_FFFF_FFFF, 64'hFFE0_0000_0000_0000, 1'b0, 1'b1},
    {2'd2, 1'b0, 1'b0, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0001, 1'b1, 1'b0},
    {2'd2, 1'b1, 1'b0, 64'hFFF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b0, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_3C00, 64'h0000_0000_0000_4000, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b1, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b1, 64'h0000_0000_0000_8001, 64'h0000_0000_0000_F800, 1'b0, 1'b1}
  };
  string tags [NV];

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    tags = '{"R3 R2", "R3", "R4", "R5", "R7", "R8", "R3", "R3", "R9", "R4 R9",
             "R6", "R7", "R8", "R5", "R3", "R4", "R9", "R7", "R8", "R2",
             "R2", "R9", "R9 R4"};
    rst_n = 1'b0; in_vld = 1'b0; fmt = 2'd0; opnd = '0;
    dn_mode = 1'b0; ftz_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "out_vld in reset", 64'(out_vld), 64'h0);
    check("R10", "result in reset", result, 64'h0);
    check("R10", "flags in reset", {62'h0, invalid, dnorm_flag}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      fmt      = VEC[i][133:132];
      dn_mode  = VEC[i][131];
      ftz_mode = VEC[i][130];
      opnd     = VEC[i][129:66];
      in_vld   = 1'b1;
      @(negedge clk);
      check(tags[i], $sformatf("vec %0d result", i), result, VEC[i][65:2]);
      check(tags[i], $sformatf("vec %0d invalid", i), 64'(invalid), 64'(VEC[i][1]));
      check(tags[i], $sformatf("vec %0d flushed", i), 64'(dnorm_flag), 64'(VEC[i][0]));
      check("R1", $sformatf("vec %0d out_vld", i), 64'(out_vld), 64'h1);
    end

    // R1: an idle cycle keeps the last result and drops valid
    in_vld = 1'b0; fmt = 2'd1; opnd = 64'h0000_0000_7F80_0001; ftz_mode = 1'b0;
    @(negedge clk);
    check("R1", "idle out_vld", 64'(out_vld), 64'h0);
    check("R1", "idle result held", result, 64'h0000_0000_0000_F800);
    check("R1", "idle flag held", 64'(dnorm_flag), 64'h1);
    check("R1", "idle invalid held", 64'(invalid), 64'h0);

    // R7: back-to-back signaling NaN then normal clears invalid
    in_vld = 1'b1; fmt = 2'd2; dn_mode = 1'b0; opnd = 64'hFFF0_0000_0000_0010;
    @(negedge clk);
    check("R7", "dbl snan result", result, 64'hFFF8_0000_0000_0010);
    check("R7", "dbl snan invalid", 64'(invalid), 64'h1);
    opnd = 64'h8010_0000_0000_0000;
    @(negedge clk);
    check("R3", "dbl min normal", result, 64'hFFE0_0000_0000_0000);
    check("R7", "invalid cleared", 64'(invalid), 64'h0);

    // R10: reset in mid-run clears outputs
    in_vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "result after reset", result, 64'h0);
    check("R10", "valid after reset", 64'(out_vld), 64'h0);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule